// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block watches the stream of host write strobes going into a paged non-volatile memory. Each strobe brings a captured address and data byte. The block looks for two fixed command codes at the start of a load period. A three-write arming code sets a persistent write-protect flag. A six-write disarming code clears it. Code bytes are masked so that the page buffer does not store them. At the end of each load period the block tells the page controller whether the loaded page may really be committed.

The page controller owns the byte-load window and the programming timer. It raises `load_end` for one cycle when a load period closes, either because the window ran out or because programming starts. That pulse aborts any partial code. It is also the only moment at which the protect flag can change. While the flag is set, a page is committed only if its load period began with a complete code. A page without the code still reaches `load_end`, but `commit_ok` stays low and nothing is stored.

Top module: `wprot_seq_det`

## Requirements
- R1: During and immediately after reset, `protect_o`, `store_mask` and `commit_ok` are all 0.
- R2: When the first three writes of a load period are 0xAA to 0x1555, 0x55 to 0x0AAA and 0xA0 to 0x1555, `protect_o` reads 1 from the cycle after that period's `load_end`.
- R3: When the first six writes of a load period are 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA and 0x20@0x1555, `protect_o` reads 0 from the cycle after that period's `load_end`.
- R4: `store_mask` is high, in the same cycle as the strobe, for every write that extends a partial or completed code, and only then. It is never high without `wr_stb`.
- R5: A write that does not match the next expected code step is not masked. It turns the rest of the period into ordinary data, and `protect_o` is left unchanged at `load_end`.
- R6: After a code completes, later writes in the same period are not masked, even when they carry code values at code addresses.
- R7: While `protect_o` is 0, `commit_ok` is 1 at every `load_end`.
- R8: While `protect_o` is 1, `commit_ok` at `load_end` is 1 only if the period began with a complete arming or disarming code. Otherwise it is 0 and the flag stays 1.
- R9: A `load_end` discards a partial code. The next period must start again from its first step.
- R10: A code is recognised only as the first writes of a period. Once an unmasked write has been seen in a period, no later write in it is masked.
- R11: A strobe in the same cycle as `load_end` belongs to the closing period. If it completes a code, that code takes effect at that `load_end`.
- R12: `protect_o` changes only in the cycle after a `load_end`. `commit_ok` is high only together with `load_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle pulse per captured host write |
| wr_addr | input | ADDR_W | Captured write address |
| wr_data | input | DATA_W | Captured write data |
| load_end | input | 1 | One-cycle pulse closing the current load period |
| protect_o | output | 1 | Persistent write-protect flag |
| commit_ok | output | 1 | With `load_end`: the loaded page may be stored |
| store_mask | output | 1 | With `wr_stb`: this byte is a command byte, do not store it |

## Verification
The bound checker covers the rules that hold on every cycle. These are: the flag moves only right after `load_end` and only together with a granted commit, `commit_ok` is high only with `load_end` and is always granted when unprotected, the mask needs a strobe, no more than six bytes are masked per period, and nothing is masked after ordinary data in a period. Only the bench scenarios can show what the exact code bytes do. It sweeps every data value at the primary address and every address with the first key. It breaks the disarm code at each of its steps while protected, aborts a code across a period boundary, and closes a code in the same cycle as `load_end`.

// File: rtl/wpsd_pkg.sv
package wpsd_pkg;

   // Position of the detector inside the current load period
   typedef enum logic [3:0] {
      ST_IDLE,   // no write yet in this period
      ST_E1,     // first key seen
      ST_E2,     // second key seen
      ST_UNL,    // arming code complete, data follows
      ST_D3,     // disarm prefix byte seen
      ST_D4,     // first key repeated
      ST_D5,     // second key repeated
      ST_DIS,    // disarming code complete, data follows
      ST_DATA    // ordinary data period, no recognition
   } wpsd_state_e;

   // Per-write decode of the code steps
   typedef struct packed {
      logic key1;    // first key at primary address
      logic key2;    // second key at secondary address
      logic arm;     // arming final byte at primary address
      logic pre;     // disarm prefix byte at primary address
      logic disarm;  // disarming final byte at primary address
   } wpsd_hit_t;

endpackage

// File: rtl/wpsd_match.sv
module wpsd_match
   import wpsd_pkg::*;
#(
   parameter int                  ADDR_W = 13,
   parameter int                  DATA_W = 8,
   parameter int                  CMP_W  = ADDR_W,
   parameter logic [ADDR_W-1:0]   ADDR_P = 13'h1555,
   parameter logic [ADDR_W-1:0]   ADDR_S = 13'h0AAA,
   parameter logic [DATA_W-1:0]   KEY1   = 8'hAA,
   parameter logic [DATA_W-1:0]   KEY2   = 8'h55,
   parameter logic [DATA_W-1:0]   ARM    = 8'hA0,
   parameter logic [DATA_W-1:0]   PRE    = 8'h80,
   parameter logic [DATA_W-1:0]   DISARM = 8'h20
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output wpsd_hit_t         hit
);

   logic on_p;
   logic on_s;

   generate
      if (CMP_W == ADDR_W) begin : g_full_cmp
         assign on_p = (addr == ADDR_P);
         assign on_s = (addr == ADDR_S);
      end else begin : g_part_cmp
         assign on_p = (addr[CMP_W-1:0] == ADDR_P[CMP_W-1:0]);
         assign on_s = (addr[CMP_W-1:0] == ADDR_S[CMP_W-1:0]);
      end
   endgenerate

   always_comb begin
      hit.key1   = on_p && (data == KEY1);
      hit.key2   = on_s && (data == KEY2);
      hit.arm    = on_p && (data == ARM);
      hit.pre    = on_p && (data == PRE);
      hit.disarm = on_p && (data == DISARM);
   end

endmodule

// File: rtl/wpsd_fsm.sv
module wpsd_fsm
   import wpsd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        stb,
   input  logic        load_end,
   input  wpsd_hit_t   hit,
   output logic        cmd_byte,
   output wpsd_state_e st_after
);

   wpsd_state_e st_q;

   // State after the current strobe, before the period boundary
   always_comb begin
      st_after = st_q;
      cmd_byte = 1'b0;
      if (stb) begin
         case (st_q)
            ST_IDLE: begin
               if (hit.key1) begin st_after = ST_E1; cmd_byte = 1'b1; end
               else          st_after = ST_DATA;
            end
            ST_E1: begin
               if (hit.key2) begin st_after = ST_E2; cmd_byte = 1'b1; end
               else          st_after = ST_DATA;
            end
            ST_E2: begin
               if (hit.arm)      begin st_after = ST_UNL; cmd_byte = 1'b1; end
               else if (hit.pre) begin st_after = ST_D3;  cmd_byte = 1'b1; end
               else              st_after = ST_DATA;
            end
            ST_D3: begin
               if (hit.key1) begin st_after = ST_D4; cmd_byte = 1'b1; end
               else          st_after = ST_DATA;
            end
            ST_D4: begin
               if (hit.key2) begin st_after = ST_D5; cmd_byte = 1'b1; end
               else          st_after = ST_DATA;
            end
            ST_D5: begin
               if (hit.disarm) begin st_after = ST_DIS; cmd_byte = 1'b1; end
               else            st_after = ST_DATA;
            end
            default: st_after = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_q <= ST_IDLE;
      else if (load_end) st_q <= ST_IDLE;
      else               st_q <= st_after;
   end

endmodule

// File: rtl/wpsd_flag.sv
module wpsd_flag
   import wpsd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_end,
   input  wpsd_state_e st_after,
   output logic        protect,
   output logic        commit_ok
);

   logic code_done;
   logic prot_q;

   assign code_done = (st_after == ST_UNL) || (st_after == ST_DIS);
   assign commit_ok = load_end && (!prot_q || code_done);
   assign protect   = prot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q <= 1'b0;
      end else if (load_end) begin
         if (st_after == ST_UNL)      prot_q <= 1'b1;
         else if (st_after == ST_DIS) prot_q <= 1'b0;
      end
   end

endmodule

// File: rtl/wprot_seq_det.sv
module wprot_seq_det
   import wpsd_pkg::*;
#(
   parameter int                  ADDR_W = 13,
   parameter int                  DATA_W = 8,
   parameter int                  CMP_W  = ADDR_W,
   parameter logic [ADDR_W-1:0]   ADDR_P = 13'h1555,
   parameter logic [ADDR_W-1:0]   ADDR_S = 13'h0AAA,
   parameter logic [DATA_W-1:0]   KEY1   = 8'hAA,
   parameter logic [DATA_W-1:0]   KEY2   = 8'h55,
   parameter logic [DATA_W-1:0]   ARM    = 8'hA0,
   parameter logic [DATA_W-1:0]   PRE    = 8'h80,
   parameter logic [DATA_W-1:0]   DISARM = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_end,
   output logic              protect_o,
   output logic              commit_ok,
   output logic              store_mask
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("wprot_seq_det: ADDR_W must be at least 2");
      end
      if (CMP_W < 1 || CMP_W > ADDR_W) begin : g_bad_cmp_w
         $error("wprot_seq_det: CMP_W must lie in 1..ADDR_W");
      end
      if (ADDR_P[CMP_W-1:0] == ADDR_S[CMP_W-1:0]) begin : g_bad_addr
         $error("wprot_seq_det: code addresses must differ in compared bits");
      end
      if (ARM == PRE) begin : g_bad_branch
         $error("wprot_seq_det: arming and disarm prefix bytes must differ");
      end
   endgenerate

   wpsd_hit_t   hit;
   wpsd_state_e st_after;
   logic        cmd_byte;

   wpsd_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W),
      .ADDR_P(ADDR_P), .ADDR_S(ADDR_S),
      .KEY1(KEY1), .KEY2(KEY2), .ARM(ARM), .PRE(PRE), .DISARM(DISARM)
   ) u_match (
      .addr (wr_addr),
      .data (wr_data),
      .hit  (hit)
   );

   wpsd_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (wr_stb),
      .load_end (load_end),
      .hit      (hit),
      .cmd_byte (cmd_byte),
      .st_after (st_after)
   );

   wpsd_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_end  (load_end),
      .st_after  (st_after),
      .protect   (protect_o),
      .commit_ok (commit_ok)
   );

   assign store_mask = cmd_byte;

endmodule

// File: rtl/wprot_seq_det_chk.sv
module wprot_seq_det_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_stb,
   input logic load_end,
   input logic protect_o,
   input logic commit_ok,
   input logic store_mask
);

   logic       seen_data;
   logic [2:0] mask_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_data <= 1'b0;
         mask_cnt  <= '0;
      end else if (load_end) begin
         seen_data <= 1'b0;
         mask_cnt  <= '0;
      end else begin
         if (wr_stb && !store_mask) seen_data <= 1'b1;
         if (store_mask && mask_cnt != 3'd7) mask_cnt <= mask_cnt + 3'd1;
      end
   end

   // R12
   a_r12_flag_moves_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(protect_o) |-> $past(load_end));
   a_r12_commit_with_end: assert property (@(posedge clk) disable iff (!rst_n)
      commit_ok |-> load_end);
   // R2
   a_r2_set_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(protect_o) |-> $past(commit_ok));
   // R3
   a_r3_clear_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(protect_o) |-> $past(commit_ok));
   // R7
   a_r7_open_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (load_end && !protect_o) |-> commit_ok);
   // R4
   a_r4_mask_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
      store_mask |-> wr_stb);
   a_r4_mask_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      store_mask |-> (mask_cnt < 3'd6));
   // R10
   a_r10_no_code_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && seen_data) |-> !store_mask);

endmodule

bind wprot_seq_det wprot_seq_det_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .load_end   (load_end),
   .protect_o  (protect_o),
   .commit_ok  (commit_ok),
   .store_mask (store_mask)
);

// File: tb/tb_wprot_seq_det.sv
module tb_wprot_seq_det;
   localparam int CLK_PERIOD = 10;
   localparam logic [12:0] PA = 13'h1555;
   localparam logic [12:0] SA = 13'h0AAA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [12:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        load_end = 1'b0;
   logic        protect_o, commit_ok, store_mask;
   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wprot_seq_det dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .load_end(load_end), .protect_o(protect_o),
      .commit_ok(commit_ok), .store_mask(store_mask)
   );

   task automatic chk(input string tag, input logic act, input logic exp, input string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   // starts and ends at a falling edge
   task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic em, input string tag);
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      #1 chk(tag, store_mask, em, "store_mask");
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic endp(input logic ec, input logic ep, input string tag);
      load_end = 1'b1;
      #1 chk(tag, commit_ok, ec, "commit_ok");
      @(negedge clk);
      load_end = 1'b0;
      chk(tag, protect_o, ep, "protect_o");
   endtask

   task automatic wr_end(input logic [12:0] a, input logic [7:0] d, input logic em,
                         input logic ec, input logic ep, input string tag);
      wr_stb = 1'b1; wr_addr = a; wr_data = d; load_end = 1'b1;
      #1 chk(tag, store_mask, em, "store_mask");
      chk(tag, commit_ok, ec, "commit_ok");
      @(negedge clk);
      wr_stb = 1'b0; load_end = 1'b0;
      chk(tag, protect_o, ep, "protect_o");
   endtask

   function automatic logic [12:0] dis_a(input int k);
      return (k == 1 || k == 4) ? SA : PA;
   endfunction
   function automatic logic [7:0] dis_d(input int k);
      case (k)
         0, 3: return 8'hAA;
         1, 4: return 8'h55;
         2:    return 8'h80;
         default: return 8'h20;
      endcase
   endfunction

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R1", protect_o, 1'b0, "protect in reset");
      chk("R1", store_mask, 1'b0, "mask in reset");
      chk("R1", commit_ok, 1'b0, "commit in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", protect_o, 1'b0, "protect after reset");

      // R4: sweep every data byte at the primary address
      for (int d = 0; d < 256; d++) begin
         wr(PA, d[7:0], (d == 8'hAA), "R4");
         endp(1'b1, 1'b0, "R7");
      end
      // R4: sweep every address with the first key
      for (int a = 0; a < 8192; a++) begin
         wr(a[12:0], 8'hAA, (a == 32'h1555), "R4");
         endp(1'b1, 1'b0, "R7");
      end

      // R2, R6, R12: arming code then data at code addresses
      wr(PA, 8'hAA, 1'b1, "R2");
      wr(SA, 8'h55, 1'b1, "R2");
      wr(PA, 8'hA0, 1'b1, "R2");
      wr(PA, 8'hAA, 1'b0, "R6");
      wr(SA, 8'h55, 1'b0, "R6");
      chk("R12", protect_o, 1'b0, "flag before end");
      endp(1'b1, 1'b1, "R2");

      // R8: protected, no code
      wr(13'h0123, 8'h5A, 1'b0, "R8");
      endp(1'b0, 1'b1, "R8");
      // R8: protected, code-prefixed data
      wr(PA, 8'hAA, 1'b1, "R8");
      wr(SA, 8'h55, 1'b1, "R8");
      wr(PA, 8'hA0, 1'b1, "R8");
      wr(13'h0040, 8'h11, 1'b0, "R8");
      endp(1'b1, 1'b1, "R8");

      // R5: break the disarming code at each step
      for (int k = 0; k < 6; k++) begin
         for (int j = 0; j < k; j++) wr(dis_a(j), dis_d(j), 1'b1, "R5");
         wr(dis_a(k), dis_d(k) ^ 8'h01, 1'b0, "R5");
         wr(dis_a(k), dis_d(k), 1'b0, "R5");
         endp(1'b0, 1'b1, "R5");
      end

      // R9: load_end aborts a partial code
      wr(PA, 8'hAA, 1'b1, "R9");
      wr(SA, 8'h55, 1'b1, "R9");
      endp(1'b0, 1'b1, "R9");
      wr(PA, 8'hA0, 1'b0, "R9");
      endp(1'b0, 1'b1, "R9");

      // R10: code after data in the same period
      wr(13'h0010, 8'h77, 1'b0, "R10");
      wr(PA, 8'hAA, 1'b0, "R10");
      wr(SA, 8'h55, 1'b0, "R10");
      wr(PA, 8'hA0, 1'b0, "R10");
      endp(1'b0, 1'b1, "R10");

      // R3: disarming code, then data
      for (int k = 0; k < 6; k++) wr(dis_a(k), dis_d(k), 1'b1, "R3");
      wr(PA, 8'h20, 1'b0, "R6");
      chk("R12", protect_o, 1'b1, "flag before end");
      endp(1'b1, 1'b0, "R3");

      // R7: unprotected plain page
      wr(13'h1FFF, 8'h00, 1'b0, "R7");
      endp(1'b1, 1'b0, "R7");

      // R11: final code byte together with load_end
      wr(PA, 8'hAA, 1'b1, "R11");
      wr(SA, 8'h55, 1'b1, "R11");
      wr_end(PA, 8'hA0, 1'b1, 1'b1, 1'b1, "R11");
      for (int k = 0; k < 5; k++) wr(dis_a(k), dis_d(k), 1'b1, "R11");
      wr_end(PA, 8'h20, 1'b1, 1'b1, 1'b0, "R11");

      finish_run();
   end
endmodule